// File: doc/BRIEF.md
# Instance-Tagged Multi-Reader Operand Queue

This block is a FIFO that holds the successive values of one renamed register of a vectorized loop body. A single producer appends values at the tail. Several consumer operand ports read from the head. Every element records its value, a ready flag and an instance number. Instance numbers count up from 1 in write order.

Each consumer keeps a private read pointer that also starts at 1. A consumer can take the head value only when the head holds the instance that its pointer names. This keeps one consumer from reading the same iteration twice, or reading past another consumer. A programmed reader count sets how many head reads retire the head. Once that many reads have landed, the head is removed and the count reloads.

After the loop limit is known, the queue hands the value of that iteration to a live-on-exit output. If the element is at the head, it comes from the head. If the element was removed only recently, it comes from a small shadow ring of past heads. A setup pulse arms the queue for a new trace. A release pulse returns it to the free pool and discards everything it holds.

Top module: `operand_queue`

## Requirements
- R1: After reset the queue is inactive: wr_ready_o is 0, rd_grant_o is 0 and exit_valid_o is 0. A setup_i pulse makes it active and empty, sets every reader pointer to 1, and loads cfg_readers_i as the reader count. During a setup_i or release_i cycle, no write is accepted and no read is granted.
- R2: A write is accepted in a cycle where wr_valid_i and wr_ready_o are both 1. It takes the next instance number, starting at 1 after setup, and is marked ready. It can be read from the next cycle on.
- R3: wr_ready_o is 0 when DEPTH elements are held. A write offered while wr_ready_o is 0 is dropped. An element removed in a cycle frees a slot from the next cycle on.
- R4: Bit r of rd_grant_o is 1 only when reader r requests, the queue is active, the head is ready, and the head's instance number equals that reader's pointer. Each grant advances that reader's pointer by one. A reader that requests without a grant stalls.
- R5: Every grant on the head counts against the programmed reader count, including several grants in the same cycle. The head is removed in the cycle in which the granted reads reach the remaining count, and the count then reloads.
- R6: rd_data_o carries the head value whenever any grant is given. Values leave in write order.
- R7: A limit_valid_i pulse is accepted only while no limit is pending and no exit value is held. While the limit is pending, the element whose instance equals the limit is captured as soon as it is at the head. exit_valid_o rises at the clock edge where the capture happens, and exit_valid_o and exit_data_o then hold until setup_i or release_i.
- R8: A pending limit whose element was among the last SHADOW_D removed heads is captured from the shadow ring instead. SHADOW_D must be a power of two.
- R9: release_i empties the queue, drops any pending limit and exit value, and makes the queue inactive.
- R10: setup_i while the queue holds data discards that data and restarts instance numbering at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | Arm the queue for a new trace and load the reader count |
| cfg_readers_i | input | $clog2(NUM_RD+1) | Number of head reads that retire one element |
| release_i | input | 1 | Return the queue to the free pool |
| wr_valid_i | input | 1 | Producer offers a value |
| wr_data_i | input | DATA_W | Producer value |
| wr_ready_o | output | 1 | Queue can accept a value |
| rd_req_i | input | NUM_RD | Per-reader read request |
| rd_grant_o | output | NUM_RD | Per-reader read success this cycle |
| rd_data_o | output | DATA_W | Head value |
| limit_valid_i | input | 1 | Loop limit is presented |
| limit_i | input | INST_W | Instance number of the final iteration |
| exit_valid_o | output | 1 | Live-on-exit value captured |
| exit_data_o | output | DATA_W | Live-on-exit value |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- A reader that asks again for a head it has already read. A design with a missing pointer compare would grant it twice and shift too early.
- Two readers that hit the head in the same cycle. If the design counted only one of them, the head would be removed one read late.
- Loop limits that name an element still behind the head and one that has already passed. The first shows a design that captures too early. The second shows a design that has no shadow path or indexes it wrongly.
- Writes offered to a full queue, release, and a setup while data is held. These show stray acceptance, stale exit values, and instance numbering that does not restart.

// File: rtl/oq_pkg.sv
package oq_pkg;
  typedef enum logic [1:0] {
    EXIT_NONE   = 2'd0,
    EXIT_HEAD   = 2'd1,
    EXIT_SHADOW = 2'd2
  } exit_src_e;
endpackage

// File: rtl/oq_store.sv
module oq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int INST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              head_ready_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [INST_W-1:0] head_inst_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [INST_W-1:0] inst_q [DEPTH];
  logic [DEPTH-1:0]  rdy_q;
  logic [AW-1:0]     head_q, tail_q;
  logic [CW-1:0]     cnt_q;
  logic [INST_W-1:0] next_inst_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] idx);
    return (idx == AW'(DEPTH - 1)) ? '0 : idx + AW'(1);
  endfunction

  assign full_o       = (cnt_q == CW'(DEPTH));
  assign empty_o      = (cnt_q == '0);
  assign head_ready_o = !empty_o && rdy_q[head_q];
  assign head_data_o  = data_q[head_q];
  assign head_inst_o  = inst_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      rdy_q       <= '0;
      next_inst_q <= INST_W'(1);
    end else if (clear_i) begin
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      rdy_q       <= '0;
      next_inst_q <= INST_W'(1);
    end else begin
      if (push_i) begin
        rdy_q[tail_q] <= 1'b1;
        tail_q        <= nxt(tail_q);
        next_inst_q   <= next_inst_q + INST_W'(1);
      end
      if (pop_i) begin
        rdy_q[head_q] <= 1'b0;
        head_q        <= nxt(head_q);
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // payload carries no reset; validity lives in rdy_q
  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) begin
      data_q[tail_q] <= push_data_i;
      inst_q[tail_q] <= next_inst_q;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
  AST_INST_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clear_i && cnt_q > CW'(1)) |=> head_inst_o == $past(head_inst_o) + INST_W'(1)); // R6
endmodule

// File: rtl/oq_readers.sv
module oq_readers #(
  parameter int NUM_RD = 3,
  parameter int INST_W = 8,
  parameter int RD_CW  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [RD_CW-1:0]  max_rd_i,
  input  logic [NUM_RD-1:0] rd_req_i,
  input  logic              head_ok_i,
  input  logic [INST_W-1:0] head_inst_i,
  output logic [NUM_RD-1:0] grant_o,
  output logic              pop_o
);
  logic [INST_W-1:0] ptr_q [NUM_RD];
  logic [RD_CW-1:0]  max_q, left_q, ngrant;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign grant_o[r] = rd_req_i[r] && head_ok_i && (head_inst_i == ptr_q[r]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                ptr_q[r] <= INST_W'(1);
      else if (load_i || clear_i) ptr_q[r] <= INST_W'(1);
      else if (grant_o[r])        ptr_q[r] <= ptr_q[r] + INST_W'(1);
    end

    AST_ONE_READ_PER_INST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[r] && !pop_o && !load_i && !clear_i) |=> !grant_o[r]); // R4
  end

  always_comb begin
    ngrant = '0;
    for (int r = 0; r < NUM_RD; r++) ngrant = ngrant + RD_CW'(grant_o[r]);
  end

  assign pop_o = (ngrant != '0) && (ngrant >= left_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      max_q  <= max_rd_i;
      left_q <= max_rd_i;
    end else if (!clear_i) begin
      if (pop_o) left_q <= max_q;
      else       left_q <= left_q - ngrant;
    end
  end

  AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && !load_i && !clear_i) |=> left_q == max_q); // R5
endmodule

// File: rtl/oq_exit.sv
module oq_exit
  import oq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int INST_W   = 8,
  parameter int SHADOW_D = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              limit_valid_i,
  input  logic [INST_W-1:0] limit_i,
  input  logic              head_valid_i,
  input  logic [INST_W-1:0] head_inst_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic              pop_i,
  output logic              exit_valid_o,
  output logic [DATA_W-1:0] exit_data_o
);
  localparam int SW = (SHADOW_D > 1) ? $clog2(SHADOW_D) : 1;

  logic [DATA_W-1:0]   sh_data_q [SHADOW_D];
  logic [INST_W-1:0]   sh_inst_q [SHADOW_D];
  logic [SHADOW_D-1:0] sh_vld_q;
  logic                pend_q;
  logic [INST_W-1:0]   lim_q;
  logic                pend;
  logic [INST_W-1:0]   lim;
  logic [SW-1:0]       lim_idx, wr_idx;
  exit_src_e           src;

  assign pend    = pend_q || (limit_valid_i && !exit_valid_o);
  assign lim     = pend_q ? lim_q : limit_i;
  assign lim_idx = lim[SW-1:0];
  assign wr_idx  = head_inst_i[SW-1:0];

  always_comb begin
    src = EXIT_NONE;
    if (pend) begin
      if (head_valid_i && head_inst_i == lim)                 src = EXIT_HEAD;
      else if (sh_vld_q[lim_idx] && sh_inst_q[lim_idx] == lim) src = EXIT_SHADOW;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      lim_q        <= '0;
      exit_valid_o <= 1'b0;
      exit_data_o  <= '0;
      sh_vld_q     <= '0;
    end else if (clear_i) begin
      pend_q       <= 1'b0;
      lim_q        <= '0;
      exit_valid_o <= 1'b0;
      exit_data_o  <= '0;
      sh_vld_q     <= '0;
    end else begin
      pend_q <= pend && (src == EXIT_NONE);
      if (pend) lim_q <= lim;
      if (src != EXIT_NONE) begin
        exit_valid_o <= 1'b1;
        exit_data_o  <= (src == EXIT_HEAD) ? head_data_i : sh_data_q[lim_idx];
      end
      if (pop_i) sh_vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (pop_i && !clear_i) begin
      sh_data_q[wr_idx] <= head_data_i;
      sh_inst_q[wr_idx] <= head_inst_i;
    end
  end

  AST_EXIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_valid_o && !clear_i) |=> (exit_valid_o && $stable(exit_data_o))); // R7
  AST_EXIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |-> !pend_q); // R7
endmodule

// File: rtl/operand_queue.sv
module operand_queue #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int NUM_RD   = 3,
  parameter int INST_W   = 8,
  parameter int SHADOW_D = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         setup_i,
  input  logic [$clog2(NUM_RD+1)-1:0]  cfg_readers_i,
  input  logic                         release_i,
  input  logic                         wr_valid_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic                         wr_ready_o,
  input  logic [NUM_RD-1:0]            rd_req_i,
  output logic [NUM_RD-1:0]            rd_grant_o,
  output logic [DATA_W-1:0]            rd_data_o,
  input  logic                         limit_valid_i,
  input  logic [INST_W-1:0]            limit_i,
  output logic                         exit_valid_o,
  output logic [DATA_W-1:0]            exit_data_o
);
  localparam int RD_CW = $clog2(NUM_RD + 1);

  logic              active_q, clear, push, pop, full, empty, head_ready;
  logic [INST_W-1:0] head_inst;
  logic [DATA_W-1:0] head_data;

  assign clear      = setup_i || release_i;
  assign wr_ready_o = active_q && !clear && !full;
  assign push       = wr_valid_i && wr_ready_o;
  assign rd_data_o  = head_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (setup_i)   active_q <= 1'b1;
    else if (release_i) active_q <= 1'b0;
  end

  oq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .INST_W(INST_W)) u_store (
    .clk_i, .rst_ni,
    .clear_i      (clear),
    .push_i       (push),
    .push_data_i  (wr_data_i),
    .pop_i        (pop),
    .full_o       (full),
    .empty_o      (empty),
    .head_ready_o (head_ready),
    .head_data_o  (head_data),
    .head_inst_o  (head_inst)
  );

  oq_readers #(.NUM_RD(NUM_RD), .INST_W(INST_W), .RD_CW(RD_CW)) u_readers (
    .clk_i, .rst_ni,
    .load_i      (setup_i),
    .clear_i     (release_i),
    .max_rd_i    (cfg_readers_i),
    .rd_req_i    (rd_req_i),
    .head_ok_i   (active_q && !clear && head_ready),
    .head_inst_i (head_inst),
    .grant_o     (rd_grant_o),
    .pop_o       (pop)
  );

  oq_exit #(.DATA_W(DATA_W), .INST_W(INST_W), .SHADOW_D(SHADOW_D)) u_exit (
    .clk_i, .rst_ni,
    .clear_i       (clear),
    .limit_valid_i (limit_valid_i),
    .limit_i       (limit_i),
    .head_valid_i  (!empty),
    .head_inst_i   (head_inst),
    .head_data_i   (head_data),
    .pop_i         (pop),
    .exit_valid_o  (exit_valid_o),
    .exit_data_o   (exit_data_o)
  );

  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (rd_grant_o == '0 && !wr_ready_o)); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !wr_ready_o); // R3
endmodule

// File: tb/operand_queue_tb.sv
module operand_queue_tb;
  localparam int P      = 10;
  localparam int DW     = 16;
  localparam int DEPTH  = 8;
  localparam int NRD    = 3;
  localparam int IW     = 8;
  localparam int SHD    = 4;
  localparam int RCW    = $clog2(NRD + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic setup = 0, rel = 0, wv = 0, lv = 0;
  logic [RCW-1:0] cfg = '0;
  logic [DW-1:0]  wd = '0;
  logic [NRD-1:0] req = '0;
  logic [IW-1:0]  li = '0;
  logic           wr_ready, exit_v;
  logic [NRD-1:0] grant;
  logic [DW-1:0]  rd_data, exit_d;

  operand_queue #(.DATA_W(DW), .DEPTH(DEPTH), .NUM_RD(NRD), .INST_W(IW), .SHADOW_D(SHD)) u_dut (
    .clk_i(clk), .rst_ni, .setup_i(setup), .cfg_readers_i(cfg), .release_i(rel),
    .wr_valid_i(wv), .wr_data_i(wd), .wr_ready_o(wr_ready),
    .rd_req_i(req), .rd_grant_o(grant), .rd_data_o(rd_data),
    .limit_valid_i(lv), .limit_i(li), .exit_valid_o(exit_v), .exit_data_o(exit_d)
  );

  always #(P/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  int mdata [256];
  int pushed = 0, popped = 0, m_left = 0, m_max = 0, m_lim = 0, m_exit_d = 0;
  int m_ptr [NRD];
  bit m_active = 0, m_pend = 0, m_exit_v = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit clr, ne, pend_eff, hit_h, hit_s, do_pop, exp_wrr;
    int ng, lim;
    logic [NRD-1:0] eg;
    #1;
    clr = setup || rel;
    ne  = pushed > popped;
    ng  = 0;
    for (int r = 0; r < NRD; r++) begin
      eg[r] = m_active && !clr && ne && req[r] && (m_ptr[r] == popped + 1);
      ng += int'(eg[r]);
    end
    exp_wrr = m_active && !clr && (pushed - popped) < DEPTH;
    chk("R4 grant", int'(grant), int'(eg));
    if (eg != '0) chk("R6 read data", int'(rd_data), mdata[popped]);
    chk("R3 wr_ready", int'(wr_ready), int'(exp_wrr));
    chk("R7 exit_valid", int'(exit_v), int'(m_exit_v));
    if (m_exit_v) chk("R7 exit_data", int'(exit_d), m_exit_d);
    pend_eff = m_pend || (lv && !m_exit_v);
    lim   = m_pend ? m_lim : int'(li);
    hit_h = pend_eff && ne && (popped + 1 == lim);
    hit_s = pend_eff && !hit_h && lim >= 1 && lim <= popped && (popped - lim) < SHD;
    if (clr) begin
      pushed = 0; popped = 0; m_pend = 0; m_exit_v = 0; m_lim = 0; m_exit_d = 0;
      for (int r = 0; r < NRD; r++) m_ptr[r] = 1;
      if (setup) begin m_active = 1; m_max = int'(cfg); m_left = int'(cfg); end
      else m_active = 0;
    end else begin
      if (hit_h || hit_s) begin m_exit_v = 1; m_exit_d = mdata[lim - 1]; end
      m_pend = pend_eff && !(hit_h || hit_s);
      if (pend_eff) m_lim = lim;
      for (int r = 0; r < NRD; r++) if (eg[r]) m_ptr[r]++;
      do_pop = (ng > 0) && (ng >= m_left);
      if (do_pop) begin popped++; m_left = m_max; end
      else m_left -= ng;
      if (wv && exp_wrr) begin mdata[pushed] = int'(wd); pushed++; end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    setup = 0; rel = 0; wv = 0; lv = 0; req = '0;
  endtask

  task automatic do_setup(int n);
    idle(); setup = 1; cfg = RCW'(n); step(); setup = 0;
  endtask

  task automatic write(int v);
    idle(); wv = 1; wd = DW'(v); step(); wv = 0;
  endtask

  task automatic read(logic [NRD-1:0] m);
    idle(); req = m; step(); req = '0;
  endtask

  initial begin
    #(P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < NRD; r++) m_ptr[r] = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk("R1 reset wr_ready", int'(wr_ready), 0);
    chk("R1 reset grant", int'(grant), 0);
    chk("R1 reset exit_valid", int'(exit_v), 0);
    @(negedge clk);

    // reader counting and gating
    do_setup(2);
    #1 chk("R1 active after setup", int'(wr_ready), 1);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) write(16'h100 + i);
    #1 chk("R3 full blocks", int'(wr_ready), 0);
    @(negedge clk);
    write(16'hdead);                       // dropped
    idle(); req = 3'b001;
    #1 chk("R2 first instance readable", int'(grant), 1);
    chk("R2 first value", int'(rd_data), 16'h100);
    step();
    req = 3'b001;
    #1 chk("R4 reread stalls", int'(grant), 0);
    step();
    req = 3'b110;
    #1 chk("R5 same-cycle grants", int'(grant), 6);
    step();
    req = 3'b001;
    #1 chk("R5 head advanced", int'(rd_data), 16'h101);
    chk("R5 reader0 granted on next", int'(grant), 1);
    step();
    idle();
    #1 chk("R3 slot freed", int'(wr_ready), 1);
    @(negedge clk);

    // limit already passed -> shadow
    do_setup(1);
    for (int i = 0; i < 6; i++) write(16'h200 + i);
    for (int i = 0; i < 4; i++) read(3'b001);
    idle(); lv = 1; li = 8'd2; step(); lv = 0;
    #1 chk("R8 shadow exit valid", int'(exit_v), 1);
    chk("R8 shadow exit data", int'(exit_d), 16'h201);
    @(negedge clk);
    idle(); lv = 1; li = 8'd5; step(); lv = 0;    // ignored, value holds
    #1 chk("R7 second limit ignored", int'(exit_d), 16'h201);
    @(negedge clk);

    // limit ahead of head -> waits
    do_setup(1);
    for (int i = 0; i < 5; i++) write(16'h300 + i);
    idle(); lv = 1; li = 8'd3; step(); lv = 0;
    #1 chk("R7 waits for head", int'(exit_v), 0);
    @(negedge clk);
    read(3'b010); read(3'b010);
    step();
    #1 chk("R7 head capture valid", int'(exit_v), 1);
    chk("R7 head capture data", int'(exit_d), 16'h302);
    @(negedge clk);

    // release
    idle(); rel = 1; step(); rel = 0;
    req = 3'b111;
    #1 chk("R9 release wr_ready", int'(wr_ready), 0);
    chk("R9 release grant", int'(grant), 0);
    chk("R9 release exit", int'(exit_v), 0);
    step();

    // setup mid-run restarts numbering
    do_setup(3);
    write(16'h400); write(16'h401);
    read(3'b001);
    do_setup(1);
    write(16'h4aa);
    idle(); req = 3'b100;
    #1 chk("R10 restart instance", int'(grant), 4);
    chk("R10 restart data", int'(rd_data), 16'h4aa);
    step();

    // random sessions
    for (int s = 0; s < 6; s++) begin
      do_setup(1 + int'($urandom_range(0, NRD - 1)));
      for (int c = 0; c < 80; c++) begin
        idle();
        wv  = ($urandom_range(0, 9) < 7);
        wd  = DW'($urandom);
        req = NRD'($urandom);
        if (c == 40) begin lv = 1; li = IW'($urandom_range(1, 20)); end
        step();
      end
      if (s % 2 == 1) begin idle(); rel = 1; step(); end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule